// File: doc/BRIEF.md
# Exhaustive Key Search Controller

This block runs a brute-force search over the lower half of a 64-bit key. A host supplies the upper 32 bits of the key and two captured 32-bit hopping codes, all in the same cycle as a start pulse. From the next cycle on, the block sweeps a lower-key counter upward from zero. Each cycle it forms one candidate key and sends it, with each of the two codes, into two decryptor pipelines of equal latency. A small tag pipeline runs beside them and carries the lower key and a last-key marker, so every decrypted pair arrives together with the key that produced it.

Each decrypted word is split into a 16-bit event counter, a 12-bit discriminator and a 4-bit function code. A key is accepted when the discriminator and the function code agree in both words and the second counter is ahead of the first by a small positive step. The block latches an accepted key and shows it to the host, which acknowledges it. The sweep keeps running while the host reads the result. When the whole lower range has drained out of the pipelines with no accepted key, the block raises a flag that asks the host for a new upper half.

The decryptor here is a stand-in with the true interface and a configurable latency. A full cipher core can replace it without changes to the control logic.

Top module: `hopsearch_top`

## Requirements
- R1: After a synchronous active-low reset, `cand_valid_o` and `exhausted_o` are 0 and no key is tested until `start_i` is seen.
- R2: A `start_i` pulse latches `upper_i`, `code_a_i` and `code_b_i`. In the cycle after that pulse, lower key 0 is tested. Lower key k is tested k cycles later, one key per cycle, in ascending order up to 2^LO_W-1, and each key is tested once.
- R3: Decryption of a code c under key {hi, lo} gives ((c XOR zero-extended lo) + hi) mod 2^32 after LAT cycles. A word's counter field is bits 15:0, its discriminator is bits 27:16 and its function code is bits 31:28. A key is rejected unless both words have equal bits 31:16.
- R4: The counter step, computed as (counter of the code-B word minus counter of the code-A word) mod 2^16, must lie in the range 1 to MAX_STEP-1 (default 7) for the key to be accepted. A step of zero, or a backward step that wraps, is rejected.
- R5: The reported key is {upper half, zero-extended lower key}, taken from the key that produced the match. For lower key k it appears on `cand_key_o` with `cand_valid_o` high k+LAT+1 clock edges after the start edge.
- R6: While `cand_valid_o` is high and `ack_i` is low, the output and its key stay unchanged, and later accepted keys are dropped. When `ack_i` is sampled, `cand_valid_o` clears. If a new key is accepted in the same cycle, that key is loaded instead.
- R7: The sweep continues after a key is accepted. When each result is acknowledged at once, every accepted key in the range is reported exactly once, in ascending order.
- R8: When no key is accepted during a sweep, `exhausted_o` rises exactly 2^LO_W+LAT edges after the start edge, once the last key has left the pipelines. It stays high until the next `start_i`, and no key is tested in the meantime.
- R9: If any key is accepted during a sweep, `exhausted_o` stays low for that sweep.
- R10: A `start_i` during a sweep restarts the search from lower key 0 with the new inputs. It discards the keys still in flight and clears `cand_valid_o` and `exhausted_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load inputs and begin a sweep |
| upper_i | input | 32 | Upper half of the key |
| code_a_i | input | 32 | First captured code |
| code_b_i | input | 32 | Second captured code |
| ack_i | input | 1 | Host has taken the reported key |
| cand_valid_o | output | 1 | An accepted key is held |
| cand_key_o | output | 64 | The accepted key |
| exhausted_o | output | 1 | Range finished with no match; reload upper half |

## Verification
A corrupt lower-key counter or a tag out of step with the decryptor data would show as a reported key or report cycle that differs from the arithmetic model. The error would appear on the first accepted key, LAT+1 cycles after that key entered. A wrong step or field test would add or drop keys in the per-sweep list that is compared in order against the model. A broken hold, flush or drain path would show as a changed held key, a leftover key after a restart, or `exhausted_o` rising one cycle early or late. The small lower width makes every sweep complete, so every key in the range passes through the match test.

// File: rtl/hopsearch_pkg.sv
// Shared layout of a decrypted code word and the fixed key geometry.
// Assumes 32-bit codes and a 64-bit key split into two equal halves.
package hopsearch_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 32;
    localparam int KEY_W  = 2 * HALF_W;
    localparam int CNT_W  = 16;
    localparam int DISC_W = 12;
    localparam int FUNC_W = 4;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic [DISC_W-1:0] disc;
        logic [CNT_W-1:0]  cnt;
    } hop_word_t;
endpackage

// File: rtl/sweep_gen.sv
// Lower-key generator: counts from zero through every LO_W-bit value,
// one per cycle, after a start pulse, then stops.
// Assumes start may arrive at any time and restarts the count.
module sweep_gen #(
    parameter int LO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            issue_valid_o,
    output logic            issue_last_o,
    output logic [LO_W-1:0] issue_lo_o
);
    localparam logic [LO_W-1:0] LO_MAX = '1;

    logic [LO_W-1:0] cnt_q;
    logic            run_q;

    // Counter advance and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LO_MAX) run_q <= 1'b0;
        end
    end

    assign issue_valid_o = run_q;
    assign issue_last_o  = run_q && (cnt_q == LO_MAX);
    assign issue_lo_o    = cnt_q;

    p_start_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (run_q && cnt_q == '0));
    p_one_key_per_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start_i && cnt_q != LO_MAX) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1));
    p_stop_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start_i && cnt_q == LO_MAX) |=> !run_q);
endmodule

// File: rtl/hop_decrypt.sv
// Stand-in decryptor with the real interface: LAT register stages,
// result (code ^ key_lo) + key_hi. A full cipher core of equal latency
// may replace it. Assumes LAT >= 1.
module hop_decrypt
    import hopsearch_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] code_i,
    input  logic [HALF_W-1:0] key_hi_i,
    input  logic [HALF_W-1:0] key_lo_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] st_q [LAT];

    // First stage: key mixing.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q[0] <= '0;
        else        st_q[0] <= (code_i ^ key_lo_i) + key_hi_i;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        // Remaining stages: carry the result to the full latency.
        always_ff @(posedge clk) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_q[i-1];
        end
    end

    assign word_o = st_q[LAT-1];
endmodule

// File: rtl/tag_pipe.sv
// Side pipeline carrying valid, last marker and lower key alongside the
// decryptors, LAT stages deep. Flush drops everything in flight.
module tag_pipe #(
    parameter int LO_W = 32,
    parameter int LAT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush_i,
    input  logic            in_valid_i,
    input  logic            in_last_i,
    input  logic [LO_W-1:0] in_lo_i,
    output logic            out_valid_o,
    output logic            out_last_o,
    output logic [LO_W-1:0] out_lo_o
);
    logic            v_q [LAT];
    logic            l_q [LAT];
    logic [LO_W-1:0] k_q [LAT];

    // Entry stage: capture the issued key unless flushed.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            v_q[0] <= 1'b0;
            l_q[0] <= 1'b0;
        end else begin
            v_q[0] <= in_valid_i;
            l_q[0] <= in_last_i;
        end
        k_q[0] <= in_lo_i;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        // Later stages: shift tags forward, cleared on flush.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i) begin
                v_q[i] <= 1'b0;
                l_q[i] <= 1'b0;
            end else begin
                v_q[i] <= v_q[i-1];
                l_q[i] <= l_q[i-1];
            end
            k_q[i] <= k_q[i-1];
        end
    end

    assign out_valid_o = v_q[LAT-1];
    assign out_last_o  = l_q[LAT-1];
    assign out_lo_o    = k_q[LAT-1];

    p_gap_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_last_o) |=> !out_valid_o);
endmodule

// File: rtl/hop_match.sv
// Acceptance test on a pair of decrypted words: equal discriminator and
// function fields, counter step (b - a) mod 2^16 in 1..MAX_STEP-1.
module hop_match
    import hopsearch_pkg::*;
#(
    parameter int MAX_STEP = 7
) (
    input  logic [WORD_W-1:0] word_a_i,
    input  logic [WORD_W-1:0] word_b_i,
    output logic              hit_o
);
    hop_word_t        wa, wb;
    logic [CNT_W-1:0] step;

    // Field split and comparison.
    always_comb begin
        wa    = hop_word_t'(word_a_i);
        wb    = hop_word_t'(word_b_i);
        step  = wb.cnt - wa.cnt;
        hit_o = (wa.disc == wb.disc) && (wa.func == wb.func)
             && (step != '0) && (step < CNT_W'(MAX_STEP));
    end
endmodule

// File: rtl/hopsearch_top.sv
// Exhaustive key search controller. Sweeps the lower key half, decrypts
// both captured codes per key, holds the first accepted key until the
// host acknowledges, and flags a drained sweep with no match.
// Assumes LO_W <= 32 and LAT >= 1.
module hopsearch_top
    import hopsearch_pkg::*;
#(
    parameter int LO_W     = 32,
    parameter int LAT      = 4,
    parameter int MAX_STEP = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [HALF_W-1:0] upper_i,
    input  logic [WORD_W-1:0] code_a_i,
    input  logic [WORD_W-1:0] code_b_i,
    input  logic              ack_i,
    output logic              cand_valid_o,
    output logic [KEY_W-1:0]  cand_key_o,
    output logic              exhausted_o
);
    localparam int NCODE = 2;

    logic [HALF_W-1:0]             hi_q;
    logic [NCODE-1:0][WORD_W-1:0]  code_q;
    logic [NCODE-1:0][WORD_W-1:0]  word;
    logic                          iss_valid, iss_last;
    logic [LO_W-1:0]               iss_lo;
    logic                          out_valid, out_last;
    logic [LO_W-1:0]               out_lo;
    logic                          match_hit, hit_now;
    logic                          cand_valid_q, hit_seen_q, exh_q;
    logic [KEY_W-1:0]              cand_key_q;

    // Host load of upper key half and captured codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            code_q <= '0;
        end else if (start_i) begin
            hi_q      <= upper_i;
            code_q[0] <= code_a_i;
            code_q[1] <= code_b_i;
        end
    end

    sweep_gen #(.LO_W(LO_W)) i_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .issue_valid_o(iss_valid), .issue_last_o(iss_last), .issue_lo_o(iss_lo)
    );

    for (genvar c = 0; c < NCODE; c++) begin : g_dec
        hop_decrypt #(.LAT(LAT)) i_dec (
            .clk(clk), .rst_n(rst_n), .code_i(code_q[c]),
            .key_hi_i(hi_q), .key_lo_i(HALF_W'(iss_lo)), .word_o(word[c])
        );
    end

    tag_pipe #(.LO_W(LO_W), .LAT(LAT)) i_tags (
        .clk(clk), .rst_n(rst_n), .flush_i(start_i),
        .in_valid_i(iss_valid), .in_last_i(iss_last), .in_lo_i(iss_lo),
        .out_valid_o(out_valid), .out_last_o(out_last), .out_lo_o(out_lo)
    );

    hop_match #(.MAX_STEP(MAX_STEP)) i_match (
        .word_a_i(word[0]), .word_b_i(word[1]), .hit_o(match_hit)
    );

    assign hit_now = out_valid && match_hit;

    // Result holding register with acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cand_valid_q <= 1'b0;
            cand_key_q   <= '0;
        end else if (hit_now && (!cand_valid_q || ack_i)) begin
            cand_valid_q <= 1'b1;
            cand_key_q   <= {hi_q, HALF_W'(out_lo)};
        end else if (ack_i) begin
            cand_valid_q <= 1'b0;
        end
    end

    // Sweep outcome: any match seen, or drained with none.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            hit_seen_q <= 1'b0;
            exh_q      <= 1'b0;
        end else begin
            if (hit_now) hit_seen_q <= 1'b1;
            if (out_valid && out_last && !hit_seen_q && !hit_now) exh_q <= 1'b1;
        end
    end

    assign cand_valid_o = cand_valid_q;
    assign cand_key_o   = cand_key_q;
    assign exhausted_o  = exh_q;

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid_q && !ack_i && !start_i) |=> (cand_valid_q && $stable(cand_key_q)));
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!cand_valid_q && !exh_q));
    p_no_exhaust_with_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exh_q |-> !cand_valid_q);
    p_idle_when_exhausted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exh_q |-> !iss_valid);
    p_key_upper_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cand_valid_q) |-> (cand_key_q[KEY_W-1:HALF_W] == hi_q));
endmodule

// File: tb/test_hopsearch_top.sv
module test_hopsearch_top;
    localparam int CLK_PERIOD = 10;
    localparam int LO_W = 8;
    localparam int LAT  = 3;
    localparam int N    = 1 << LO_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] upper = '0, code_a = '0, code_b = '0;
    logic        ack = 1'b0;
    logic        cand_valid;
    logic [63:0] cand_key;
    logic        exhausted;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    hopsearch_top #(.LO_W(LO_W), .LAT(LAT), .MAX_STEP(7)) i_hopsearch_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .upper_i(upper),
        .code_a_i(code_a), .code_b_i(code_b), .ack_i(ack),
        .cand_valid_o(cand_valid), .cand_key_o(cand_key), .exhausted_o(exhausted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] up,
                                          input logic [7:0] lo);
        return (c ^ {24'b0, lo}) + up;
    endfunction

    function automatic bit accepted(input logic [31:0] up, input logic [31:0] ca,
                                    input logic [31:0] cb, input logic [7:0] lo);
        logic [31:0] pa, pb;
        logic [15:0] d;
        pa = model(ca, up, lo);
        pb = model(cb, up, lo);
        d  = pb[15:0] - pa[15:0];
        return (pa[31:16] == pb[31:16]) && (d != 16'd0) && (d < 16'd7);
    endfunction

    // One full sweep, checked against the arithmetic model.
    task automatic sweep(input logic [31:0] up, input logic [31:0] ca,
                         input logic [31:0] cb, input bit do_ack, input string tag);
        int exp_lo [N];
        int n_exp = 0;
        int idx = 0;
        bit exp_v;
        for (int k = 0; k < N; k++)
            if (accepted(up, ca, cb, 8'(k))) begin exp_lo[n_exp] = k; n_exp++; end
        @(negedge clk);
        start = 1'b1; upper = up; code_a = ca; code_b = cb; ack = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!cand_valid && !exhausted, "R10", {tag, " cleared by start"},
            {62'b0, cand_valid, exhausted}, 64'd0);
        for (int e = 1; e <= N + LAT + 2; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (do_ack) begin
                if (cand_valid) begin
                    if (idx < n_exp)
                        chk(cand_key == {up, 24'b0, 8'(exp_lo[idx])} && e == exp_lo[idx] + LAT + 1,
                            "R5", {tag, " key/cycle"}, cand_key, {up, 24'b0, 8'(exp_lo[idx])});
                    else
                        chk(1'b0, "R7", {tag, " extra key"}, cand_key, 64'd0);
                    idx++;
                    ack = 1'b1;
                end else begin
                    ack = 1'b0;
                end
            end else begin
                exp_v = (n_exp > 0) && (e >= exp_lo[0] + LAT + 1);
                chk(cand_valid == exp_v, "R6", {tag, " held valid"}, 64'(cand_valid), 64'(exp_v));
                if (exp_v)
                    chk(cand_key == {up, 24'b0, 8'(exp_lo[0])}, "R6", {tag, " held key"},
                        cand_key, {up, 24'b0, 8'(exp_lo[0])});
            end
            if (e == N + LAT - 1)
                chk(!exhausted, "R8", {tag, " early exhausted"}, 64'(exhausted), 64'd0);
            if (e >= N + LAT) begin
                if (n_exp == 0) chk(exhausted, "R8", {tag, " exhausted"}, 64'(exhausted), 64'd1);
                else            chk(!exhausted, "R9", {tag, " exhausted"}, 64'(exhausted), 64'd0);
            end
        end
        ack = 1'b0;
        if (do_ack) chk(idx == n_exp, "R7", {tag, " count"}, 64'(idx), 64'(n_exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk(!cand_valid && !exhausted, "R1", "reset state",
                {62'b0, cand_valid, exhausted}, 64'd0);
        end
        // R2/R3/R7: many consecutive accepted keys, immediate ack
        sweep(32'h0000_0000, 32'h1234_0000, 32'h1234_0005, 1'b1, "R2 R3");
        // R3: carries into the field bits differ per key
        sweep(32'h0000_FFFA, 32'h5A5A_0000, 32'h5A5A_0003, 1'b1, "R3 carry");
        // R4: counter step wraps modulo 2^16
        sweep(32'h0000_0000, 32'h7777_FFFE, 32'h7777_0001, 1'b1, "R4 wrap");
        // R4: equal codes, step zero, nothing accepted
        sweep(32'h1111_1111, 32'h2468_0010, 32'h2468_0010, 1'b1, "R4 zero");
        // R3: differing discriminator
        sweep(32'h0000_0000, 32'h0ABC_0000, 32'h0ABD_0002, 1'b1, "R3 field");
        // R6: no acknowledge, first key held for the whole sweep
        sweep(32'h0000_0000, 32'h1234_0000, 32'h1234_0005, 1'b0, "R6 hold");
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        chk(!cand_valid, "R6", "ack clears", 64'(cand_valid), 64'd0);
        // R10: restart in the middle of a sweep
        @(negedge clk);
        start = 1'b1; upper = 32'h0; code_a = 32'h1234_0000; code_b = 32'h1234_0005;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(cand_valid, "R10", "first sweep found key", 64'(cand_valid), 64'd1);
        sweep(32'h0000_0000, 32'h0ABC_0000, 32'h0ABD_0002, 1'b1, "R10 restart");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule